// File: doc/BRIEF.md
# Configurable 16-bit CPU Slave Bus Front End

This block sits between an external processor's asynchronous 16-bit slave bus and a byte-organised register space inside the chip. It synchronises the chip select, read strobe and write strobes into the internal clock and turns each completed bus cycle into one word request on an internal register port. Each request carries a word address, data, and per-byte enables in a fixed internal order: the even byte is in bits 7:0 and the odd byte is in bits 15:8. Read data returns on a response input and is driven back onto the bus. Two bus conventions are chosen once after reset by writing a mode word. The first is the byte-lane order, big or little endian per 16-bit word. The second is the write style, either two write strobes or one write strobe with two byte enables.

For each port, a slave DMA handshake lets an acknowledged access reach that port's FIFO data window without any address. The block raises the DMA request while the FIFO can move at least one word. An active-low interrupt output can drive both levels, or drive low only and float otherwise.

The request side is a valid/ready stream. `req_valid` rises when the block has a request to offer. Once it is up, the request stays up and its payload stays unchanged until a cycle in which `req_ready` is high. No new request is taken from the bus while one is pending, so the processor must not start the next bus cycle until the previous one has been accepted. Read responses have no back-pressure. They are captured in any cycle where `rsp_valid` is high.

Top module: `cpubus_front`

## Requirements
- R1: After reset, `req_valid` is 0, all `dreq_n` are 1 while the FIFO levels are 0, `bus_oe` is 0 with the bus idle, and the mode is big endian with two write strobes.
- R2: `req_addr` carries the bus word address `wa_i` unchanged. `req_be` bit 0 enables the even byte and bit 1 enables the odd byte, and a request never has both enables at 0.
- R3: In big-endian mode, the even byte uses bus lane 15:8 and the odd byte uses lane 7:0, for both writes and read data.
- R4: In little-endian mode, the even byte uses bus lane 7:0 and the odd byte uses lane 15:8, for both writes and read data.
- R5: In two-strobe mode, `wrh_n` low writes bus lane 15:8 and `wrl_n` low writes bus lane 7:0. Either strobe may be used alone.
- R6: In byte-enable mode, `wrl_n` is the only write strobe, `wrh_n` low enables lane 15:8 and `bel_n` low enables lane 7:0. A pulse on `wrh_n` alone produces no request.
- R7: The first write after reset to word address `MODE_WADDR` that enables bus lane 7:0 sets the mode from that lane: bit 0 = 1 selects little endian and bit 1 = 1 selects byte-enable mode. This write is not forwarded. Later writes to that address are forwarded as normal. `soft_rst` leaves the mode unchanged.
- R8: With `dack_n[p]` low, an access needs no chip select and produces a request with `req_dma` = 1, `req_port` = p and `req_addr` = 0, whatever the address.
- R9: One cycle after the inputs change, `dreq_n[p]` is 0 exactly when the selected FIFO level is 2 bytes or more. The selected level is `fifo_fill` when `dma_to_cpu[p]` is 1 and `fifo_room` otherwise.
- R10: With `int_drain_only` = 0, `int_oe` = 1 and `int_n` = not `irq`. With `int_drain_only` = 1, `int_n` = 0 and `int_oe` = `irq`.
- R11: `bus_oe` is 1 only while `rd_n` is low together with `cs_n` or some `dack_n`. While it is 1 after a read, `bus_dout` holds the response word in the current lane order.
- R12: A write becomes a request only after its strobes are released, once per bus cycle. Under back-pressure the request is held with a stable payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears everything including the mode |
| soft_rst | input | 1 | Synchronous soft reset, clears the access state but keeps the mode |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wrl_n | input | 1 | Low-lane write strobe, or the single write strobe in byte-enable mode |
| wrh_n | input | 1 | High-lane write strobe, or the high byte enable in byte-enable mode |
| bel_n | input | 1 | Low byte enable, used in byte-enable mode only |
| wa_i | input | ADDR_W | Bus word address |
| bus_din | input | 16 | Bus write data |
| bus_dout | output | 16 | Bus read data |
| bus_oe | output | 1 | Bus output enable |
| dack_n | input | NPORT | Per-port active-low DMA acknowledge |
| dreq_n | output | NPORT | Per-port active-low DMA request |
| dma_to_cpu | input | NPORT | Per-port DMA direction, 1 = FIFO to processor |
| fifo_fill | input | NPORT*LVL_W | Per-port FIFO bytes available |
| fifo_room | input | NPORT*LVL_W | Per-port FIFO bytes free |
| irq | input | 1 | Interrupt pending |
| int_drain_only | input | 1 | Interrupt drive style, 1 = drive low only |
| int_n | output | 1 | Active-low interrupt level |
| int_oe | output | 1 | Interrupt output enable |
| req_valid | output | 1 | Register request valid |
| req_ready | input | 1 | Register request accepted |
| req_write | output | 1 | Request is a write |
| req_dma | output | 1 | Request targets a FIFO data window |
| req_port | output | PORT_W | Port of a DMA request |
| req_addr | output | ADDR_W | Request word address |
| req_be | output | 2 | Byte enables, bit 0 = even, bit 1 = odd |
| req_wdata | output | 16 | Write data in internal order |
| rsp_valid | input | 1 | Read response valid |
| rsp_rdata | input | 16 | Read response data in internal order |

## Verification
The bench uses the default parameters: a 9-bit word address, two DMA ports, 13-bit FIFO levels and a mode word at address 0. With two ports, both the acknowledge-to-port mapping and a nonzero `req_port` can be exercised. The wide level inputs allow the request threshold to be probed at 1 and 2 bytes as well as at large values. Running the same bus cycles before and after the mode write covers both lane orders and both write styles.

// File: rtl/cbf_pkg.sv
package cbf_pkg;
  typedef struct packed {
    logic byte_en_mode;
    logic little_end;
  } bus_mode_t;

  function automatic logic [15:0] swap_bytes(input logic [15:0] w);
    return {w[7:0], w[15:8]};
  endfunction
endpackage

// File: rtl/cbf_sync.sv
module cbf_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '1;
      q      <= '1;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/cbf_lane_map.sv
module cbf_lane_map (
  input  logic        little_end,
  input  logic [15:0] bus_word,
  input  logic [1:0]  bus_en,     // [1] lane 15:8, [0] lane 7:0
  output logic [15:0] int_word,   // [7:0] even byte, [15:8] odd byte
  output logic [1:0]  int_en      // [0] even, [1] odd
);
  always_comb begin
    if (little_end) begin
      int_word = bus_word;
      int_en   = bus_en;
    end else begin
      int_word = cbf_pkg::swap_bytes(bus_word);
      int_en   = {bus_en[0], bus_en[1]};
    end
  end
endmodule

// File: rtl/cbf_dma_req.sv
module cbf_dma_req #(
  parameter int LVL_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             to_cpu,
  input  logic [LVL_W-1:0] fill,
  input  logic [LVL_W-1:0] room,
  output logic             dreq_n
);
  localparam logic [LVL_W-1:0] WORD_BYTES = LVL_W'(2);

  logic [LVL_W-1:0] level;
  assign level = to_cpu ? fill : room;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dreq_n <= 1'b1;
    else        dreq_n <= (level < WORD_BYTES);
  end

  AST_DREQ_DRAINED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (to_cpu && fill < WORD_BYTES) |=> dreq_n); // R9
  AST_DREQ_FULL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!to_cpu && room >= WORD_BYTES) |=> !dreq_n); // R9
endmodule

// File: rtl/cpubus_front.sv
module cpubus_front #(
  parameter int ADDR_W     = 9,
  parameter int NPORT      = 2,
  parameter int LVL_W      = 13,
  parameter int MODE_WADDR = 0,
  localparam int PORT_W    = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   soft_rst,
  input  logic                   cs_n,
  input  logic                   rd_n,
  input  logic                   wrl_n,
  input  logic                   wrh_n,
  input  logic                   bel_n,
  input  logic [ADDR_W-1:0]      wa_i,
  input  logic [15:0]            bus_din,
  output logic [15:0]            bus_dout,
  output logic                   bus_oe,
  input  logic [NPORT-1:0]       dack_n,
  output logic [NPORT-1:0]       dreq_n,
  input  logic [NPORT-1:0]       dma_to_cpu,
  input  logic [NPORT*LVL_W-1:0] fifo_fill,
  input  logic [NPORT*LVL_W-1:0] fifo_room,
  input  logic                   irq,
  input  logic                   int_drain_only,
  output logic                   int_n,
  output logic                   int_oe,
  output logic                   req_valid,
  input  logic                   req_ready,
  output logic                   req_write,
  output logic                   req_dma,
  output logic [PORT_W-1:0]      req_port,
  output logic [ADDR_W-1:0]      req_addr,
  output logic [1:0]             req_be,
  output logic [15:0]            req_wdata,
  input  logic                   rsp_valid,
  input  logic [15:0]            rsp_rdata
);
  import cbf_pkg::*;

  localparam int SYNC_W = 5 + NPORT;

  // ---- strobe synchronisation ----
  logic [SYNC_W-1:0] sync_q;
  cbf_sync #(.W(SYNC_W)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({dack_n, bel_n, wrh_n, wrl_n, rd_n, cs_n}),
    .q(sync_q)
  );

  logic cs_s, rd_s, wrl_s, wrh_s, bel_s;
  logic [NPORT-1:0] dack_s;
  assign {dack_s, bel_s, wrh_s, wrl_s, rd_s, cs_s} = sync_q;

  bus_mode_t mode_q;
  logic      mode_locked;

  logic              dma_any;
  logic [PORT_W-1:0] port_sel;
  assign dma_any = ~&dack_s;

  always_comb begin
    port_sel = '0;
    for (int i = NPORT - 1; i >= 0; i--)
      if (!dack_s[i]) port_sel = PORT_W'(i);
  end

  logic sel, wr_act, rd_act;
  logic [1:0] lane_now;
  assign sel      = ~cs_s | dma_any;
  assign wr_act   = sel & (mode_q.byte_en_mode ? ~wrl_s : (~wrl_s | ~wrh_s));
  assign rd_act   = sel & ~rd_s;
  assign lane_now = mode_q.byte_en_mode ? {~wrh_s, ~bel_s} : {~wrh_s, ~wrl_s};

  // ---- capture of the write cycle ----
  logic              wr_act_q, rd_act_q;
  logic [15:0]       cap_data;
  logic [ADDR_W-1:0] cap_addr;
  logic [1:0]        cap_lanes;
  logic              cap_dma;
  logic [PORT_W-1:0] cap_port;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_act_q  <= 1'b0;
      rd_act_q  <= 1'b0;
      cap_data  <= '0;
      cap_addr  <= '0;
      cap_lanes <= '0;
      cap_dma   <= 1'b0;
      cap_port  <= '0;
    end else if (soft_rst) begin
      wr_act_q  <= 1'b0;
      rd_act_q  <= 1'b0;
      cap_lanes <= '0;
      cap_dma   <= 1'b0;
    end else begin
      wr_act_q <= wr_act;
      rd_act_q <= rd_act;
      if (wr_act) begin
        cap_data  <= bus_din;
        cap_addr  <= wa_i;
        cap_dma   <= dma_any;
        cap_port  <= port_sel;
        cap_lanes <= wr_act_q ? (cap_lanes | lane_now) : lane_now;
      end
    end
  end

  logic        wr_done, rd_start, mode_hit, slot_free;
  logic [15:0] wr_word;
  logic [1:0]  wr_be;
  assign wr_done   = wr_act_q & ~wr_act;
  assign rd_start  = rd_act & ~rd_act_q;
  assign mode_hit  = ~mode_locked & ~cap_dma &
                     (cap_addr == ADDR_W'(MODE_WADDR)) & cap_lanes[0];
  assign slot_free = ~req_valid | req_ready;

  cbf_lane_map u_wmap (
    .little_end(mode_q.little_end),
    .bus_word(cap_data), .bus_en(cap_lanes),
    .int_word(wr_word), .int_en(wr_be)
  );

  // ---- mode register: cleared only by the hard reset ----
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q      <= '0;
      mode_locked <= 1'b0;
    end else if (wr_done && mode_hit) begin
      mode_q.byte_en_mode <= cap_data[1];
      mode_q.little_end   <= cap_data[0];
      mode_locked         <= 1'b1;
    end
  end

  // ---- request stream ----
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_valid <= 1'b0;
      req_write <= 1'b0;
      req_dma   <= 1'b0;
      req_port  <= '0;
      req_addr  <= '0;
      req_be    <= '0;
      req_wdata <= '0;
    end else if (soft_rst) begin
      req_valid <= 1'b0;
    end else begin
      if (req_valid && req_ready) req_valid <= 1'b0;
      if (wr_done && !mode_hit && cap_lanes != 2'b00 && slot_free) begin
        req_valid <= 1'b1;
        req_write <= 1'b1;
        req_dma   <= cap_dma;
        req_port  <= cap_port;
        req_addr  <= cap_dma ? '0 : cap_addr;
        req_be    <= wr_be;
        req_wdata <= wr_word;
      end else if (rd_start && slot_free) begin
        req_valid <= 1'b1;
        req_write <= 1'b0;
        req_dma   <= dma_any;
        req_port  <= port_sel;
        req_addr  <= dma_any ? '0 : wa_i;
        req_be    <= 2'b11;
        req_wdata <= '0;
      end
    end
  end

  // ---- read return path ----
  logic [15:0] rd_word_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rd_word_q <= '0;
    else if (soft_rst)  rd_word_q <= '0;
    else if (rsp_valid) rd_word_q <= rsp_rdata;
  end

  assign bus_dout = mode_q.little_end ? rd_word_q : swap_bytes(rd_word_q);
  assign bus_oe   = (~cs_n | ~&dack_n) & ~rd_n;

  // ---- interrupt drive style ----
  assign int_n  = int_drain_only ? 1'b0 : ~irq;
  assign int_oe = int_drain_only ? irq : 1'b1;

  // ---- per-port DMA request ----
  for (genvar p = 0; p < NPORT; p++) begin : g_dma
    cbf_dma_req #(.LVL_W(LVL_W)) u_dreq (
      .clk(clk), .rst_n(rst_n),
      .to_cpu(dma_to_cpu[p]),
      .fill(fifo_fill[p*LVL_W +: LVL_W]),
      .room(fifo_room[p*LVL_W +: LVL_W]),
      .dreq_n(dreq_n[p])
    );
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (req_valid && !req_ready) |=> (req_valid &&
      $stable({req_write, req_dma, req_port, req_addr, req_be, req_wdata}))); // R12
  AST_COMMIT_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    ($rose(req_valid) && req_write) |-> !wr_act_q); // R12
  AST_MODE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    mode_locked |=> (mode_locked && $stable(mode_q))); // R7
  AST_DMA_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_dma) |-> (req_addr == '0)); // R8
  AST_BE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_be != 2'b00)); // R2
endmodule

// File: tb/cpubus_front_bench.sv
module cpubus_front_bench;
  localparam int AW = 9;
  localparam int NP = 2;
  localparam int LW = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, wrl_n = 1'b1, wrh_n = 1'b1, bel_n = 1'b1;
  logic [AW-1:0] wa_i = '0;
  logic [15:0] bus_din = '0;
  logic [15:0] bus_dout;
  logic bus_oe;
  logic [NP-1:0] dack_n = '1;
  logic [NP-1:0] dreq_n;
  logic [NP-1:0] dma_to_cpu = '0;
  logic [NP*LW-1:0] fifo_fill = '0;
  logic [NP*LW-1:0] fifo_room = '0;
  logic irq = 1'b0, int_drain_only = 1'b0;
  logic int_n, int_oe;
  logic req_valid, req_ready = 1'b1, req_write, req_dma;
  logic [0:0] req_port;
  logic [AW-1:0] req_addr;
  logic [1:0] req_be;
  logic [15:0] req_wdata;
  logic rsp_valid = 1'b0;
  logic [15:0] rsp_rdata = '0;

  always #2 clk = ~clk;

  cpubus_front u_cpubus_front (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .cs_n(cs_n), .rd_n(rd_n), .wrl_n(wrl_n), .wrh_n(wrh_n), .bel_n(bel_n),
    .wa_i(wa_i), .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe),
    .dack_n(dack_n), .dreq_n(dreq_n), .dma_to_cpu(dma_to_cpu),
    .fifo_fill(fifo_fill), .fifo_room(fifo_room),
    .irq(irq), .int_drain_only(int_drain_only), .int_n(int_n), .int_oe(int_oe),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_dma(req_dma), .req_port(req_port), .req_addr(req_addr),
    .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  int n_chk = 0;
  int n_err = 0;
  int n_hs  = 0;
  bit b_le  = 1'b0;
  bit b_bem = 1'b0;
  logic [29:0] exp_q[$];
  string       tag_q[$];

  function automatic logic [15:0] model_rd(input logic [AW-1:0] a);
    return {a[7:0] ^ 8'h5A, a[7:0]};
  endfunction

  function automatic logic [15:0] sw(input logic [15:0] w);
    return {w[7:0], w[15:8]};
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // register model answering reads
  always @(posedge clk) begin
    rsp_valid <= rst_n && req_valid && req_ready && !req_write;
    rsp_rdata <= model_rd(req_addr);
  end

  // monitor: pops the scoreboard at each accepted request
  always @(posedge clk) begin
    if (rst_n && req_valid && req_ready) begin
      logic [29:0] got;
      got = {req_write, req_dma, req_port, req_addr, req_be, req_wdata};
      n_hs++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R12 unexpected request", 32'(got), 32'h0);
      end else begin
        logic [29:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(got == e, t, 32'(got), 32'(e));
      end
    end
  end

  task automatic push_exp(input bit w, input bit d, input bit p,
                          input logic [AW-1:0] a, input logic [1:0] be,
                          input logic [15:0] wd, input string t);
    exp_q.push_back({w, d, p, a, be, wd});
    tag_q.push_back(t);
  endtask

  task automatic select(input int dport);
    if (dport < 0) cs_n = 1'b0;
    else           dack_n[dport] = 1'b0;
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [15:0] d,
                           input bit hi, input bit lo, input int dport,
                           input bit expect_req, input string t);
    logic [15:0] iw;
    logic [1:0]  ibe;
    iw  = b_le ? d : sw(d);
    ibe = b_le ? {hi, lo} : {lo, hi};
    @(negedge clk);
    wa_i = a; bus_din = d;
    select(dport);
    repeat (2) @(negedge clk);
    if (b_bem) begin
      wrl_n = 1'b0; wrh_n = ~hi; bel_n = ~lo;
    end else begin
      wrh_n = ~hi; wrl_n = ~lo;
    end
    repeat (5) @(negedge clk);
    if (expect_req)
      push_exp(1'b1, dport >= 0, (dport > 0), (dport >= 0) ? '0 : a, ibe, iw, t);
    wrl_n = 1'b1; wrh_n = 1'b1; bel_n = 1'b1;
    repeat (5) @(negedge clk);
    cs_n = 1'b1; dack_n = '1;
    repeat (3) @(negedge clk);
  endtask

  task automatic bus_read(input logic [AW-1:0] a, input int dport, input string t);
    logic [15:0] iw, ew;
    logic [AW-1:0] ea;
    ea = (dport >= 0) ? '0 : a;
    iw = model_rd(ea);
    ew = b_le ? iw : sw(iw);
    push_exp(1'b0, dport >= 0, (dport > 0), ea, 2'b11, 16'h0, t);
    @(negedge clk);
    wa_i = a;
    select(dport);
    repeat (2) @(negedge clk);
    rd_n = 1'b0;
    repeat (10) @(negedge clk);
    check(bus_oe == 1'b1, {t, " oe"}, 32'(bus_oe), 32'h1);
    check(bus_dout == ew, {t, " data"}, 32'(bus_dout), 32'(ew));
    rd_n = 1'b1;
    repeat (2) @(negedge clk);
    cs_n = 1'b1; dack_n = '1;
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", 32'h0, 32'h1);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    int hs0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check(req_valid == 1'b0, "R1 req_valid", 32'(req_valid), 32'h0);
    check(dreq_n == 2'b11, "R1 dreq_n", 32'(dreq_n), 32'h3);
    check(bus_oe == 1'b0, "R1 bus_oe", 32'(bus_oe), 32'h0);

    // R3 R5 R2: big endian, two strobes
    bus_write(9'h005, 16'h1234, 1, 1, -1, 1, "R3 R2 both lanes big endian");
    bus_write(9'h006, 16'hAB00, 1, 0, -1, 1, "R5 high strobe only");
    bus_write(9'h007, 16'h00CD, 0, 1, -1, 1, "R5 low strobe only");
    bus_read(9'h009, -1, "R3 read big endian");

    // R7: mode write to word 0, lane 7:0 -> little endian + byte enables
    hs0 = n_hs;
    bus_write(9'h000, 16'h0003, 0, 1, -1, 0, "R7 mode");
    b_le = 1'b1; b_bem = 1'b1;
    check(n_hs == hs0, "R7 mode write not forwarded", 32'(n_hs), 32'(hs0));

    // R4 R6: little endian, byte-enable writes
    bus_write(9'h004, 16'h1234, 1, 1, -1, 1, "R4 R6 both enables little endian");
    bus_write(9'h011, 16'h0055, 0, 1, -1, 1, "R6 low enable only");
    bus_write(9'h012, 16'h7700, 1, 0, -1, 1, "R6 high enable only");

    // R6: wrh_n pulse alone does nothing
    hs0 = n_hs;
    @(negedge clk); cs_n = 1'b0; wa_i = 9'h013;
    repeat (2) @(negedge clk); wrh_n = 1'b0;
    repeat (5) @(negedge clk); wrh_n = 1'b1;
    repeat (8) @(negedge clk); cs_n = 1'b1;
    repeat (3) @(negedge clk);
    check(n_hs == hs0, "R6 lone wrh_n ignored", 32'(n_hs), 32'(hs0));
    check(req_valid == 1'b0, "R6 no pending request", 32'(req_valid), 32'h0);

    bus_read(9'h003, -1, "R4 read little endian");

    // R7: word 0 now forwarded; soft reset keeps mode
    bus_write(9'h000, 16'h0000, 1, 1, -1, 1, "R7 word 0 after lock");
    @(negedge clk); soft_rst = 1'b1;
    repeat (2) @(negedge clk); soft_rst = 1'b0;
    repeat (2) @(negedge clk);
    bus_write(9'h002, 16'hBEEF, 1, 1, -1, 1, "R7 mode kept after soft reset");
    bus_read(9'h021, -1, "R7 read order kept after soft reset");

    // R8: DMA accesses
    bus_write(9'h055, 16'hC0DE, 1, 1, 1, 1, "R8 DMA write port 1");
    bus_read(9'h0AA, 0, "R8 R11 DMA read port 0");

    // R11: read strobe without select
    @(negedge clk); rd_n = 1'b0;
    repeat (3) @(negedge clk);
    check(bus_oe == 1'b0, "R11 oe without select", 32'(bus_oe), 32'h0);
    rd_n = 1'b1;
    repeat (3) @(negedge clk);

    // R12: back-pressure
    req_ready = 1'b0;
    bus_write(9'h033, 16'h4242, 1, 1, -1, 1, "R12 held request");
    check(req_valid == 1'b1, "R12 valid held under back-pressure", 32'(req_valid), 32'h1);
    @(negedge clk); req_ready = 1'b1;
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R12 scoreboard drained", 32'(exp_q.size()), 32'h0);

    // R9: DMA request thresholds
    dma_to_cpu = 2'b01;
    fifo_fill[LW-1:0] = LW'(1);
    repeat (3) @(negedge clk);
    check(dreq_n[0] == 1'b1, "R9 one byte available", 32'(dreq_n[0]), 32'h1);
    fifo_fill[LW-1:0] = LW'(2);
    repeat (2) @(negedge clk);
    check(dreq_n[0] == 1'b0, "R9 one word available", 32'(dreq_n[0]), 32'h0);
    fifo_room[2*LW-1:LW] = LW'(1);
    repeat (2) @(negedge clk);
    check(dreq_n[1] == 1'b1, "R9 one byte free", 32'(dreq_n[1]), 32'h1);
    fifo_room[2*LW-1:LW] = LW'(300);
    repeat (2) @(negedge clk);
    check(dreq_n[1] == 1'b0, "R9 plenty free", 32'(dreq_n[1]), 32'h0);

    // R10: interrupt styles
    irq = 1'b1; #1;
    check({int_n, int_oe} == 2'b01, "R10 push-pull active", 32'({int_n, int_oe}), 32'h1);
    irq = 1'b0; #1;
    check({int_n, int_oe} == 2'b11, "R10 push-pull idle", 32'({int_n, int_oe}), 32'h3);
    int_drain_only = 1'b1; #1;
    check(int_oe == 1'b0, "R10 drain idle floats", 32'(int_oe), 32'h0);
    irq = 1'b1; #1;
    check({int_n, int_oe} == 2'b01, "R10 drain active", 32'({int_n, int_oe}), 32'h1);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R2 all expected requests seen", 32'(exp_q.size()), 32'h0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule